// File: doc/BRIEF.md
# Network Controller Command and Interrupt Register Block

This block holds the host-visible control state of a network controller: a command register whose bits launch one-shot actions, an interrupt status and mask pair that drives a single level interrupt line, configuration registers that may only be changed while the controller sits in software reset, three error tally counters, and a 32-bit down-counting general-purpose timer that is split into two 16-bit halves.

The host talks to it over a word-addressed bus. A write happens on any clock edge where `bus_sel` and `bus_we` are high. A read happens on an edge where `bus_sel` is high and `bus_we` is low, and the data appears on `bus_rdata` after that edge. Other modules report events through the `status_set_i` pulse vector. They finish long actions through `tx_done_i` and `cam_done_i`. The block starts those actions through single-cycle strobes. The timer counts down once for each `tick_i` pulse, and one pulse stands for one 5 MHz period.

Top module: `nic_ctrl_regs`

## Requirements
- R1: Word addresses are: 0 command, 1 data configuration, 2 receive control, 3 transmit control, 4 interrupt mask, 5 interrupt status, 6 timer low half, 7 timer high half, 8 revision, 9 end-of-buffer count, 10 to 12 tally counters, and 13 second configuration. Read data is registered and appears after the edge that samples the read. Unmapped addresses read 0.
- R2: After hardware reset, the command register reads 0x0094 (reset 0x0080, stop-timer 0x0010 and receive-disable 0x0004 all set). Revision reads 0x0004, end-of-buffer count reads 0x02F8, and mask, status, timer and `irq_o` are all 0.
- R3: `irq_o` is high exactly when the mask AND status is nonzero. It takes its new value on the same edge on which a mask write, status write or status set lands.
- R4: A status write clears only the bits that are written as 1 and are currently set. A bit pulsed on `status_set_i` becomes 1, and this set wins over a clear in the same cycle.
- R5: A mask write stores only bits 14:0, so bit 15 always reads 0.
- R6: Command bits are: halt-transmit bit 0, transmit bit 1, receive-disable bit 2, receive-enable bit 3, stop-timer bit 4, start-timer bit 5, reset bit 7, read-resource bit 8 and load-CAM bit 9. Only bits in 0x03BF are latched. A written transmit, receive-enable, receive-disable, read-resource or load-CAM bit raises its strobe for the one cycle after the write. Read-resource never stays set. Transmit stays set until `tx_done_i` and load-CAM stays set until `cam_done_i`.
- R7: Writing receive-enable clears receive-disable and the reverse. Writing start-timer clears stop-timer and the reverse.
- R8: While reset mode is on, a command write without bit 7 only turns reset mode off. It latches no other bit and raises no strobe.
- R9: A command write with bit 7 clears load-CAM, read-resource, transmit and halt-transmit, and then sets reset and receive-disable.
- R10: The data configuration register takes writes only in reset mode, masked with 0xBFFF. The second configuration register takes writes only in reset mode, masked with 0xF017. Outside reset mode, writes to either one leave it unchanged.
- R11: Transmit-control writes keep bits 15:12 and receive-control writes keep bits 15:5. Tally writes store the bitwise inverse of the data. The revision register ignores writes.
- R12: While stop-timer is clear, each `tick_i` pulse lowers the 32-bit timer by one. While stop-timer is set, the timer holds its value.
- R13: A tick at count 0 while the timer runs reloads 0xFFFFFFFF and sets status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| tick_i | input | 1 | Timer decrement enable, one 5 MHz period |
| status_set_i | input | 16 | Per-bit status set pulses |
| tx_done_i | input | 1 | Transmit finished, clears the transmit command bit |
| cam_done_i | input | 1 | Address table load finished, clears the load-CAM bit |
| irq_o | output | 1 | Level interrupt |
| tx_start_o | output | 1 | Transmit strobe |
| rx_enable_o | output | 1 | Receiver enable strobe |
| rx_disable_o | output | 1 | Receiver disable strobe |
| rra_read_o | output | 1 | Read-next-resource strobe |
| cam_load_o | output | 1 | Address table load strobe |

## Verification
A corrupted status or mask bit shows up on `irq_o` on the very next edge. A bad command state shows up either as a strobe that is missing or unexpected in the cycle after a write, or as a wrong value in the next command read. A reset-mode flag that is stuck on or off shows up at once, because writes to the configuration registers land when they should be ignored or are ignored when they should land. A timer fault shows up as a count that is off by one on readback after a known number of ticks. It also shows up as status bit 7 failing to rise, which raises `irq_o`, on the tick that wraps the count from zero.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int TW = 2 * DW;
  localparam int NTALLY = 3;
  typedef logic [AW-1:0] addr_t;
  typedef logic [DW-1:0] word_t;

  localparam addr_t A_CMD   = 4'd0;
  localparam addr_t A_DCFG  = 4'd1;
  localparam addr_t A_RXCTL = 4'd2;
  localparam addr_t A_TXCTL = 4'd3;
  localparam addr_t A_MASK  = 4'd4;
  localparam addr_t A_STAT  = 4'd5;
  localparam addr_t A_TLO   = 4'd6;
  localparam addr_t A_THI   = 4'd7;
  localparam addr_t A_REV   = 4'd8;
  localparam addr_t A_EOB   = 4'd9;
  localparam addr_t A_TAL0  = 4'd10;
  localparam addr_t A_DCFG2 = 4'd13;

  localparam int C_HTX   = 0;
  localparam int C_TXP   = 1;
  localparam int C_RXDIS = 2;
  localparam int C_RXEN  = 3;
  localparam int C_STP   = 4;
  localparam int C_ST    = 5;
  localparam int C_RST   = 7;
  localparam int C_RRRA  = 8;
  localparam int C_LCAM  = 9;

  localparam word_t CMD_KEEP   = 16'h03BF;
  localparam word_t DCFG_KEEP  = 16'hBFFF;
  localparam word_t DCFG2_KEEP = 16'hF017;
  localparam word_t TXCTL_KEEP = 16'hF000;
  localparam word_t RXCTL_KEEP = 16'hFFE0;
  localparam word_t MASK_KEEP  = 16'h7FFF;
  localparam word_t CMD_RST    = 16'h0094;
  localparam word_t REV_VAL    = 16'h0004;
  localparam word_t EOB_RST    = 16'h02F8;
  localparam int    ST_UFLOW   = 7;
endpackage

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
  import nic_regs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cmd_we,
  input  word_t wdata,
  input  logic  tx_done,
  input  logic  cam_done,
  output word_t cmd_q,
  output logic  tx_stb,
  output logic  rxen_stb,
  output logic  rxdis_stb,
  output logic  rra_stb,
  output logic  cam_stb
);
  word_t cmd_n;
  logic  tx_n, rxen_n, rxdis_n, rra_n, cam_n;

  always_comb begin
    cmd_n   = cmd_q;
    tx_n    = 1'b0;
    rxen_n  = 1'b0;
    rxdis_n = 1'b0;
    rra_n   = 1'b0;
    cam_n   = 1'b0;
    if (cmd_we) begin
      if (cmd_q[C_RST] && !wdata[C_RST]) begin
        cmd_n[C_RST] = 1'b0;
      end else begin
        cmd_n = cmd_q | (wdata & CMD_KEEP);
        if (wdata[C_TXP]) tx_n = 1'b1;
        if (wdata[C_RXDIS]) begin
          cmd_n[C_RXEN] = 1'b0;
          rxdis_n       = 1'b1;
        end
        if (wdata[C_RXEN]) begin
          cmd_n[C_RXDIS] = 1'b0;
          rxen_n         = 1'b1;
        end
        if (wdata[C_STP]) cmd_n[C_ST]  = 1'b0;
        if (wdata[C_ST])  cmd_n[C_STP] = 1'b0;
        if (wdata[C_RST]) begin
          cmd_n[C_LCAM]  = 1'b0;
          cmd_n[C_RRRA]  = 1'b0;
          cmd_n[C_TXP]   = 1'b0;
          cmd_n[C_HTX]   = 1'b0;
          cmd_n[C_RST]   = 1'b1;
          cmd_n[C_RXDIS] = 1'b1;
        end
        if (wdata[C_RRRA]) begin
          cmd_n[C_RRRA] = 1'b0;
          rra_n         = 1'b1;
        end
        if (wdata[C_LCAM]) cam_n = 1'b1;
      end
    end else begin
      if (tx_done)  cmd_n[C_TXP]  = 1'b0;
      if (cam_done) cmd_n[C_LCAM] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= CMD_RST;
      tx_stb    <= 1'b0;
      rxen_stb  <= 1'b0;
      rxdis_stb <= 1'b0;
      rra_stb   <= 1'b0;
      cam_stb   <= 1'b0;
    end else begin
      cmd_q     <= cmd_n;
      tx_stb    <= tx_n;
      rxen_stb  <= rxen_n;
      rxdis_stb <= rxdis_n;
      rra_stb   <= rra_n;
      cam_stb   <= cam_n;
    end
  end

  // R8
  leave_reset_only_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_q[C_RST] && !wdata[C_RST]) |=>
      (!cmd_q[C_RST] && !tx_stb && !rxen_stb && !rxdis_stb && !rra_stb && !cam_stb));

  // R9
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && wdata[C_RST]) |=>
      (cmd_q[C_RST] && cmd_q[C_RXDIS] && !cmd_q[C_TXP] && !cmd_q[C_LCAM] && !cmd_q[C_HTX]));

  // R6
  rra_not_kept_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_q[C_RRRA]);

  // R7
  rx_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && !cmd_q[C_RST] && wdata[C_RXEN] && !wdata[C_RXDIS] && !wdata[C_RST]) |=>
      (cmd_q[C_RXEN] && !cmd_q[C_RXDIS]));
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
  import nic_regs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  mask_we,
  input  logic  stat_we,
  input  word_t wdata,
  input  word_t set_vec,
  output word_t mask_q,
  output word_t stat_q,
  output logic  irq_q
);
  word_t mask_n, stat_n;

  always_comb begin
    mask_n = mask_we ? (wdata & MASK_KEEP) : mask_q;
    stat_n = (stat_we ? (stat_q & ~wdata) : stat_q) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_n;
      stat_q <= stat_n;
      irq_q  <= |(mask_n & stat_n);
    end
  end

  // R3
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|(mask_q & stat_q)));

  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_we && set_vec == '0) |=> stat_q == ($past(stat_q) & ~$past(wdata)));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  // R5
  mask_top_chk: assert property (@(posedge clk) disable iff (rst)
    !mask_q[DW-1]);
endmodule

// File: rtl/nic_wd_timer.sv
module nic_wd_timer
  import nic_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          lo_we,
  input  logic          hi_we,
  input  word_t         wdata,
  input  logic          run,
  input  logic          tick,
  output logic [TW-1:0] cnt_q,
  output logic          uflow
);
  logic step;

  assign step  = run && tick && !lo_we && !hi_we;
  assign uflow = step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (lo_we) begin
      cnt_q[DW-1:0] <= wdata;
    end else if (hi_we) begin
      cnt_q[TW-1:DW] <= wdata;
    end else if (step) begin
      if (cnt_q == '0) cnt_q <= '1;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R12
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (step && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R12
  hold_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !lo_we && !hi_we) |=> $stable(cnt_q));

  // R13
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    uflow |=> (&cnt_q));
endmodule

// File: rtl/nic_ctrl_regs.sv
module nic_ctrl_regs
  import nic_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tick_i,
  input  logic [DW-1:0] status_set_i,
  input  logic          tx_done_i,
  input  logic          cam_done_i,
  output logic          irq_o,
  output logic          tx_start_o,
  output logic          rx_enable_o,
  output logic          rx_disable_o,
  output logic          rra_read_o,
  output logic          cam_load_o
);
  logic          wr, rd, rst_mode, uflow;
  word_t         cmd_q, mask_q, stat_q, set_vec;
  word_t         dcfg_q, dcfg2_q, rxctl_q, txctl_q, eob_q;
  word_t         tally_q [NTALLY];
  word_t         rmux;
  logic [TW-1:0] cnt_q;

  assign wr       = bus_sel && bus_we;
  assign rd       = bus_sel && !bus_we;
  assign rst_mode = cmd_q[C_RST];

  always_comb begin
    set_vec           = status_set_i;
    set_vec[ST_UFLOW] = status_set_i[ST_UFLOW] | uflow;
  end

  nic_cmd_ctrl u_cmd (
    .clk      (clk),
    .rst      (rst),
    .cmd_we   (wr && bus_addr == A_CMD),
    .wdata    (bus_wdata),
    .tx_done  (tx_done_i),
    .cam_done (cam_done_i),
    .cmd_q    (cmd_q),
    .tx_stb   (tx_start_o),
    .rxen_stb (rx_enable_o),
    .rxdis_stb(rx_disable_o),
    .rra_stb  (rra_read_o),
    .cam_stb  (cam_load_o)
  );

  nic_irq_ctrl u_irq (
    .clk    (clk),
    .rst    (rst),
    .mask_we(wr && bus_addr == A_MASK),
    .stat_we(wr && bus_addr == A_STAT),
    .wdata  (bus_wdata),
    .set_vec(set_vec),
    .mask_q (mask_q),
    .stat_q (stat_q),
    .irq_q  (irq_o)
  );

  nic_wd_timer u_tmr (
    .clk  (clk),
    .rst  (rst),
    .lo_we(wr && bus_addr == A_TLO),
    .hi_we(wr && bus_addr == A_THI),
    .wdata(bus_wdata),
    .run  (!cmd_q[C_STP]),
    .tick (tick_i),
    .cnt_q(cnt_q),
    .uflow(uflow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dcfg_q  <= '0;
      dcfg2_q <= '0;
      rxctl_q <= '0;
      txctl_q <= '0;
      eob_q   <= EOB_RST;
    end else if (wr) begin
      case (bus_addr)
        A_DCFG:  if (rst_mode) dcfg_q  <= bus_wdata & DCFG_KEEP;
        A_DCFG2: if (rst_mode) dcfg2_q <= bus_wdata & DCFG2_KEEP;
        A_RXCTL: rxctl_q <= bus_wdata & RXCTL_KEEP;
        A_TXCTL: txctl_q <= bus_wdata & TXCTL_KEEP;
        A_EOB:   eob_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NTALLY; g++) begin : g_tally
    localparam addr_t TA = addr_t'(int'(A_TAL0) + g);
    always_ff @(posedge clk) begin
      if (rst)                        tally_q[g] <= '0;
      else if (wr && bus_addr == TA)  tally_q[g] <= ~bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CMD:   rmux = cmd_q;
      A_DCFG:  rmux = dcfg_q;
      A_RXCTL: rmux = rxctl_q;
      A_TXCTL: rmux = txctl_q;
      A_MASK:  rmux = mask_q;
      A_STAT:  rmux = stat_q;
      A_TLO:   rmux = cnt_q[DW-1:0];
      A_THI:   rmux = cnt_q[TW-1:DW];
      A_REV:   rmux = REV_VAL;
      A_EOB:   rmux = eob_q;
      A_DCFG2: rmux = dcfg2_q;
      default: rmux = '0;
    endcase
    for (int i = 0; i < NTALLY; i++) begin
      if (bus_addr == addr_t'(int'(A_TAL0) + i)) rmux = tally_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rmux;
  end

  // R10
  dcfg_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr == A_DCFG && !rst_mode) |=> $stable(dcfg_q));

  // R10
  dcfg2_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr == A_DCFG2 && !rst_mode) |=> $stable(dcfg2_q));

  // R13
  uflow_status_chk: assert property (@(posedge clk) disable iff (rst)
    uflow |=> stat_q[ST_UFLOW]);
endmodule

// File: tb/tb_nic_ctrl_regs.sv
module tb_nic_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        tick_i = 1'b0, tx_done_i = 1'b0, cam_done_i = 1'b0;
  logic [15:0] status_set_i = '0;
  logic        irq_o, tx_start_o, rx_enable_o, rx_disable_o, rra_read_o, cam_load_o;

  int n_chk = 0, n_err = 0;
  logic [4:0]  stb;   // {tx, rxen, rxdis, rra, cam}
  logic [15:0] rv;

  always #5 clk = ~clk;

  nic_ctrl_regs dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_i(tick_i),
    .status_set_i(status_set_i), .tx_done_i(tx_done_i), .cam_done_i(cam_done_i),
    .irq_o(irq_o), .tx_start_o(tx_start_o), .rx_enable_o(rx_enable_o),
    .rx_disable_o(rx_disable_o), .rra_read_o(rra_read_o), .cam_load_o(cam_load_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    stb = {tx_start_o, rx_enable_o, rx_disable_o, rra_read_o, cam_load_o};
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, {16'h0, v}, {16'h0, exp});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(posedge clk); #1; tick_i = 1'b0;
    end
  endtask

  task automatic set_pulse(input logic [15:0] v);
    @(negedge clk); status_set_i = v;
    @(posedge clk); #1; status_set_i = '0;
  endtask

  task automatic t_reset;
    rd_chk("R2 cmd", 4'd0, 16'h0094);
    rd_chk("R2 rev", 4'd8, 16'h0004);
    rd_chk("R2 eob", 4'd9, 16'h02F8);
    rd_chk("R2 status", 4'd5, 16'h0000);
    rd_chk("R2 mask", 4'd4, 16'h0000);
    rd_chk("R1 unmapped", 4'd15, 16'h0000);
    check("R2 irq", irq_o, 0);
  endtask

  task automatic t_cfg_gate;
    wr(4'd1, 16'hFFFF);
    rd_chk("R10 dcfg in reset", 4'd1, 16'hBFFF);
    wr(4'd13, 16'hFFFF);
    rd_chk("R10 dcfg2 in reset", 4'd13, 16'hF017);
    wr(4'd0, 16'h0002);
    check("R8 no strobe on leave", stb, 0);
    rd_chk("R8 cmd after leave", 4'd0, 16'h0014);
    wr(4'd1, 16'h1234);
    rd_chk("R10 dcfg outside reset", 4'd1, 16'hBFFF);
    wr(4'd13, 16'h0000);
    rd_chk("R10 dcfg2 outside reset", 4'd13, 16'hF017);
  endtask

  task automatic t_masks;
    wr(4'd3, 16'hFFFF);
    rd_chk("R11 txctl", 4'd3, 16'hF000);
    wr(4'd2, 16'hFFFF);
    rd_chk("R11 rxctl", 4'd2, 16'hFFE0);
    wr(4'd11, 16'h1234);
    rd_chk("R11 tally", 4'd11, 16'hEDCB);
    wr(4'd12, 16'h0000);
    rd_chk("R11 tally2", 4'd12, 16'hFFFF);
    wr(4'd8, 16'h5555);
    rd_chk("R11 rev ro", 4'd8, 16'h0004);
    wr(4'd4, 16'hFFFF);
    rd_chk("R5 mask", 4'd4, 16'h7FFF);
    wr(4'd4, 16'h0000);
  endtask

  task automatic t_commands;
    wr(4'd0, 16'h0008);
    check("R6 rxen strobe", stb, 5'b01000);
    rd_chk("R7 rxen clears rxdis", 4'd0, 16'h0018);
    wr(4'd0, 16'h0002);
    check("R6 tx strobe", stb, 5'b10000);
    rd_chk("R6 tx bit held", 4'd0, 16'h001A);
    @(negedge clk); tx_done_i = 1'b1; @(posedge clk); #1; tx_done_i = 1'b0;
    rd_chk("R6 tx done clears", 4'd0, 16'h0018);
    wr(4'd0, 16'h0100);
    check("R6 rra strobe", stb, 5'b00010);
    rd_chk("R6 rra not kept", 4'd0, 16'h0018);
    wr(4'd0, 16'h0200);
    check("R6 cam strobe", stb, 5'b00001);
    wr(4'd0, 16'h0440);
    check("R6 unlatched bits no strobe", stb, 0);
    rd_chk("R6 cam held, unlatched ignored", 4'd0, 16'h0218);
    @(negedge clk); cam_done_i = 1'b1; @(posedge clk); #1; cam_done_i = 1'b0;
    rd_chk("R6 cam done clears", 4'd0, 16'h0018);
    wr(4'd0, 16'h0004);
    check("R6 rxdis strobe", stb, 5'b00100);
    rd_chk("R7 rxdis clears rxen", 4'd0, 16'h0014);
    wr(4'd0, 16'h0008);
  endtask

  task automatic t_irq;
    set_pulse(16'h0008);
    check("R3 masked irq low", irq_o, 0);
    rd_chk("R4 set pulse", 4'd5, 16'h0008);
    wr(4'd4, 16'h0008);
    check("R3 irq after mask write", irq_o, 1);
    wr(4'd5, 16'h0001);
    rd_chk("R4 clear of unset bit", 4'd5, 16'h0008);
    check("R3 irq kept", irq_o, 1);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'd5; bus_wdata = 16'h0008;
    status_set_i = 16'h0008;
    @(posedge clk); #1; bus_sel = 1'b0; bus_we = 1'b0; status_set_i = '0;
    rd_chk("R4 set beats clear", 4'd5, 16'h0008);
    wr(4'd5, 16'h0008);
    check("R3 irq after status clear", irq_o, 0);
    rd_chk("R4 w1c", 4'd5, 16'h0000);
  endtask

  task automatic t_timer;
    ticks(2);
    rd_chk("R12 stopped hold", 4'd6, 16'h0000);
    rd_chk("R13 no uflow when stopped", 4'd5, 16'h0000);
    wr(4'd6, 16'h0003);
    wr(4'd7, 16'h0000);
    wr(4'd0, 16'h0020);
    rd_chk("R7 start clears stop", 4'd0, 16'h0028);
    ticks(3);
    rd_chk("R12 count", 4'd6, 16'h0000);
    check("R13 no early status", irq_o, 0);
    wr(4'd4, 16'h0080);
    ticks(1);
    check("R13 irq on underflow", irq_o, 1);
    rd_chk("R13 reload lo", 4'd6, 16'hFFFF);
    rd_chk("R13 reload hi", 4'd7, 16'hFFFF);
    rd_chk("R13 status bit7", 4'd5, 16'h0080);
    ticks(2);
    rd_chk("R12 running", 4'd6, 16'hFFFD);
    wr(4'd0, 16'h0010);
    rd_chk("R7 stop clears start", 4'd0, 16'h0018);
    ticks(4);
    rd_chk("R12 hold after stop", 4'd6, 16'hFFFD);
    wr(4'd5, 16'h0080);
    check("R3 irq drop", irq_o, 0);
  endtask

  task automatic t_soft_reset;
    wr(4'd0, 16'h0202);
    check("R6 two strobes", stb, 5'b10001);
    rd_chk("R6 cmd pending", 4'd0, 16'h021A);
    wr(4'd0, 16'h0080);
    check("R9 no strobe", stb, 0);
    rd_chk("R9 soft reset cmd", 4'd0, 16'h009C);
    wr(4'd1, 16'h0001);
    rd_chk("R10 dcfg writable again", 4'd1, 16'h0001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_cfg_gate();
    t_masks();
    t_commands();
    t_irq();
    t_timer();
    t_soft_reset();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule